// File: doc/BRIEF.md
# Block Copy and Search Engine

This block is the memory sequencer behind the byte-block move and byte-block search instructions of an 8-bit processor core. A command loads a source pointer, a destination pointer and a 16-bit byte count. The command also selects copy or search, ascending or descending addresses, and one step or repeat. The engine then walks memory one byte per iteration through a request/acknowledge port. In copy mode it moves each byte from the source address to the destination address. In search mode it subtracts each byte from the accumulator and keeps only the flags.

The block returns the updated pointers, the updated count and the new flag byte. It also returns a running cost in processor clock states, so the core can charge the instruction correctly. A repeated command can be held off between iterations by a suspend request. In that case the engine stops with work left and raises `redo`, and the core rewinds its program counter by two bytes so that the instruction runs again later. The flag byte uses S=bit7, Z=bit6, Y=bit5, H=bit4, X=bit3, P/V=bit2, N=bit1, C=bit0.

Top module: `blkx_engine`

## Requirements
- R1: A copy iteration reads the byte at the source pointer and writes that byte at the destination pointer. Both pointers then move by +1 when `cmd_down`=0 or by -1 when `cmd_down`=1, wrapping modulo 2^16.
- R2: A search iteration (`cmd_cmp`=1) reads the byte at the source pointer and issues no memory write. Only the source pointer moves by ±1; the destination pointer keeps its loaded value.
- R3: Every iteration decrements the count by one, and a count of 0 wraps to 0xFFFF. Flag bit2 (P/V) is 1 when the count after the decrement is nonzero and 0 when it is zero.
- R4: After a copy iteration, flag bits 7, 6 and 0 keep their incoming values, and bits 4 and 1 are 0. Bit 3 equals bit 3 of (byte + accumulator) mod 256, and bit 5 equals bit 1 of that sum.
- R5: After a search iteration with d = (accumulator - byte) mod 256: bit7 = d[7], bit6 = (d==0), bit4 = the borrow out of bit 3 (bit 4 of accumulator^byte^d), bit1 = 1, and bit0 keeps its incoming value.
- R6: After a search iteration, with n = (d - bit4) mod 256, flag bit 3 equals n[3] and flag bit 5 equals n[1].
- R7: A repeated copy keeps iterating until the count after a decrement is zero.
- R8: A repeated search stops after the first iteration whose difference d is zero, or after the first iteration whose count reaches zero, whichever comes first.
- R9: `tstates` restarts at 0 on each command. Each iteration followed by another iteration, or by a suspension, adds 21. The final iteration of a completed command (including a single step) adds 16.
- R10: `suspend_req` is sampled only after an iteration has finished. If a repeat would continue, the engine stops with the count nonzero, P/V set and `redo`=1. On a single step or on a finishing iteration, `suspend_req` has no effect and `redo` stays 0.
- R11: `busy` is high from the cycle after an accepted command until the final flags are written. `done` is then high for exactly one cycle. `mem_req` stays high with a stable address until `mem_ack`.
- R12: After reset, `busy`, `done`, `mem_req`, `redo`, the pointers, the count, the flags and `tstates` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start a command (accepted when not busy) |
| cmd_cmp | input | 1 | 0 = copy, 1 = search |
| cmd_down | input | 1 | 0 = ascending addresses, 1 = descending |
| cmd_rep | input | 1 | 0 = one iteration, 1 = repeat |
| acc | input | 8 | Accumulator value |
| flags_in | input | 8 | Flag byte before the command |
| src_in | input | 16 | Initial source pointer |
| dst_in | input | 16 | Initial destination pointer |
| cnt_in | input | 16 | Initial byte count |
| suspend_req | input | 1 | Request to stop a repeat between iterations |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Transaction complete; read data valid |
| mem_rdata | input | 8 | Read data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| src_out | output | 16 | Current source pointer |
| dst_out | output | 16 | Current destination pointer |
| cnt_out | output | 16 | Current byte count |
| flags_out | output | 8 | Resulting flag byte |
| redo | output | 1 | Repeat was suspended; instruction must run again |
| tstates | output | 24 | Accumulated clock-state cost of the command |

## Verification
The hardest states to reach from the ports are the two early exits of a repeat: a search that hits a match part-way through, and a suspension that arrives exactly between iterations. The stimulus fills memory with a permutation pattern in which every byte is unique. It then sets the accumulator to the byte lying a known number of steps ahead, so the match iteration is known in advance. Suspension is driven by holding `suspend_req` high through a repeated command, which must stop after one iteration. It is also held through single-step and last-iteration commands, where it must change nothing. Memory latency is varied on every run so that request holding is exercised.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    typedef enum logic {
        OP_COPY = 1'b0,
        OP_CMP  = 1'b1
    } blk_op_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD   = 3'd1,
        S_WR   = 3'd2,
        S_STEP = 3'd3,
        S_FIN  = 3'd4
    } blk_state_e;

    // flag bit positions
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_Y  = 5;
    localparam int FB_H  = 4;
    localparam int FB_X  = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    // clock-state cost of one iteration
    localparam int T_CONT = 21;
    localparam int T_LAST = 16;

    typedef struct packed {
        logic [7:0] flags;
        logic       match;
    } flag_res_t;

    function automatic flag_res_t copy_flags(input logic [7:0] fin,
                                             input logic [7:0] val,
                                             input logic [7:0] a,
                                             input logic       cnt_nz);
        logic [7:0] sum;
        flag_res_t  r;
        sum           = val + a;
        r.flags       = 8'h00;
        r.flags[FB_S] = fin[FB_S];
        r.flags[FB_Z] = fin[FB_Z];
        r.flags[FB_C] = fin[FB_C];
        r.flags[FB_X] = sum[3];
        r.flags[FB_Y] = sum[1];
        r.flags[FB_PV] = cnt_nz;
        r.match       = 1'b0;
        return r;
    endfunction

    function automatic flag_res_t cmp_flags(input logic [7:0] fin,
                                            input logic [7:0] val,
                                            input logic [7:0] a,
                                            input logic       cnt_nz);
        logic [7:0] diff;
        logic [7:0] adj;
        logic       hb;
        flag_res_t  r;
        diff           = a - val;
        hb             = (a[4] ^ val[4]) ^ diff[4];
        adj            = diff - {7'd0, hb};
        r.flags        = 8'h00;
        r.flags[FB_S]  = diff[7];
        r.flags[FB_Z]  = (diff == 8'h00);
        r.flags[FB_H]  = hb;
        r.flags[FB_X]  = adj[3];
        r.flags[FB_Y]  = adj[1];
        r.flags[FB_PV] = cnt_nz;
        r.flags[FB_N]  = 1'b1;
        r.flags[FB_C]  = fin[FB_C];
        r.match        = (diff == 8'h00);
        return r;
    endfunction

endpackage

// File: rtl/blkx_flagcalc.sv
module blkx_flagcalc
    import blkx_pkg::*;
(
    input  blk_op_e    op,
    input  logic [7:0] fin,
    input  logic [7:0] val,
    input  logic [7:0] a,
    input  logic       cnt_nz,
    output logic [7:0] fout,
    output logic       match
);
    flag_res_t res_copy;
    flag_res_t res_cmp;
    flag_res_t res_sel;

    always_comb begin
        res_copy = copy_flags(fin, val, a, cnt_nz);
        res_cmp  = cmp_flags(fin, val, a, cnt_nz);
        res_sel  = (op == OP_CMP) ? res_cmp : res_copy;
        fout     = res_sel.flags;
        match    = res_sel.match;
    end
endmodule

// File: rtl/blkx_ptrs.sv
module blkx_ptrs #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic          down,
    input  logic          move_dst,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_dec
);
    localparam int NPTR = 2;

    logic [AW-1:0] ptr_q    [NPTR];
    logic [AW-1:0] ptr_init [NPTR];
    logic          ptr_move [NPTR];

    assign ptr_init[0] = src_in;
    assign ptr_init[1] = dst_in;
    assign ptr_move[0] = 1'b1;
    assign ptr_move[1] = move_dst;

    genvar g;
    generate
        for (g = 0; g < NPTR; g++) begin : g_ptr
            always_ff @(posedge clk) begin
                if (rst)
                    ptr_q[g] <= '0;
                else if (load)
                    ptr_q[g] <= ptr_init[g];
                else if (step && ptr_move[g])
                    ptr_q[g] <= down ? (ptr_q[g] - 1'b1) : (ptr_q[g] + 1'b1);
            end
        end
    endgenerate

    assign src_q   = ptr_q[0];
    assign dst_q   = ptr_q[1];
    assign cnt_dec = cnt_q - 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= cnt_in;
        else if (step)
            cnt_q <= cnt_dec;
    end

    p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

    p_src_move_r1: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (src_q != $past(src_q)));
endmodule

// File: rtl/blkx_engine.sv
module blkx_engine
    import blkx_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic          cmd_cmp,
    input  logic          cmd_down,
    input  logic          cmd_rep,
    input  logic [7:0]    acc,
    input  logic [7:0]    flags_in,
    input  logic [AW-1:0] src_in,
    input  logic [AW-1:0] dst_in,
    input  logic [CW-1:0] cnt_in,
    input  logic          suspend_req,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic          mem_ack,
    input  logic [7:0]    mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] src_out,
    output logic [AW-1:0] dst_out,
    output logic [CW-1:0] cnt_out,
    output logic [7:0]    flags_out,
    output logic          redo,
    output logic [TW-1:0] tstates
);
    blk_state_e    state_q;
    blk_op_e       op_q;
    logic          down_q;
    logic          rep_q;
    logic [7:0]    acc_q;
    logic [7:0]    flags_q;
    logic [7:0]    data_q;
    logic          redo_q;
    logic [TW-1:0] tst_q;

    logic          start;
    logic          step_en;
    logic [CW-1:0] cnt_dec;
    logic          cnt_nz;
    logic [7:0]    flags_nx;
    logic          match;
    logic          cont;

    assign busy    = (state_q == S_RD) || (state_q == S_WR) || (state_q == S_STEP);
    assign done    = (state_q == S_FIN);
    assign start   = cmd_valid && !busy;
    assign step_en = (state_q == S_STEP);
    assign cnt_nz  = (cnt_dec != '0);
    assign cont    = rep_q && cnt_nz && !((op_q == OP_CMP) && match);

    blkx_ptrs #(.AW(AW), .CW(CW)) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .step     (step_en),
        .down     (down_q),
        .move_dst (op_q == OP_COPY),
        .src_in   (src_in),
        .dst_in   (dst_in),
        .cnt_in   (cnt_in),
        .src_q    (src_out),
        .dst_q    (dst_out),
        .cnt_q    (cnt_out),
        .cnt_dec  (cnt_dec)
    );

    blkx_flagcalc u_flags (
        .op     (op_q),
        .fin    (flags_q),
        .val    (data_q),
        .a      (acc_q),
        .cnt_nz (cnt_nz),
        .fout   (flags_nx),
        .match  (match)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            op_q    <= OP_COPY;
            down_q  <= 1'b0;
            rep_q   <= 1'b0;
            acc_q   <= 8'h00;
            flags_q <= 8'h00;
            data_q  <= 8'h00;
            redo_q  <= 1'b0;
            tst_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE, S_FIN: begin
                    if (start) begin
                        op_q    <= cmd_cmp ? OP_CMP : OP_COPY;
                        down_q  <= cmd_down;
                        rep_q   <= cmd_rep;
                        acc_q   <= acc;
                        flags_q <= flags_in;
                        redo_q  <= 1'b0;
                        tst_q   <= '0;
                        state_q <= S_RD;
                    end else begin
                        state_q <= S_IDLE;
                    end
                end
                S_RD: begin
                    if (mem_ack) begin
                        data_q  <= mem_rdata;
                        state_q <= (op_q == OP_COPY) ? S_WR : S_STEP;
                    end
                end
                S_WR: begin
                    if (mem_ack)
                        state_q <= S_STEP;
                end
                S_STEP: begin
                    flags_q <= flags_nx;
                    if (cont) begin
                        tst_q <= tst_q + TW'(T_CONT);
                        if (suspend_req) begin
                            redo_q  <= 1'b1;
                            state_q <= S_FIN;
                        end else begin
                            state_q <= S_RD;
                        end
                    end else begin
                        tst_q   <= tst_q + TW'(T_LAST);
                        state_q <= S_FIN;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign mem_req   = (state_q == S_RD) || (state_q == S_WR);
    assign mem_we    = (state_q == S_WR);
    assign mem_addr  = (state_q == S_WR) ? dst_out : src_out;
    assign mem_wdata = data_q;
    assign flags_out = flags_q;
    assign redo      = redo_q;
    assign tstates   = tst_q;

    p_req_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_no_write_cmp_r2: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (op_q == OP_COPY));

    p_pv_count_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (flags_out[FB_PV] == (cnt_out != '0)));

    p_redo_left_r10: assert property (@(posedge clk) disable iff (rst)
        (done && redo) |-> (cnt_out != '0));

    p_cost_step_r9: assert property (@(posedge clk) disable iff (rst)
        step_en |=> ((tst_q == TW'($past(tst_q) + TW'(T_CONT))) ||
                     (tst_q == TW'($past(tst_q) + TW'(T_LAST)))));
endmodule

// File: tb/tb_blkx_engine.sv
module tb_blkx_engine;
    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst;
    logic        cmd_valid, cmd_cmp, cmd_down, cmd_rep;
    logic [7:0]  acc, flags_in;
    logic [15:0] src_in, dst_in, cnt_in;
    logic        suspend_req;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        busy, done, redo;
    logic [15:0] src_out, dst_out, cnt_out;
    logic [7:0]  flags_out;
    logic [23:0] tstates;

    logic [7:0]  mem [0:255];
    int          lat_sel;
    int          wcnt;
    int          wr_cnt;
    int          n_chk;
    int          n_fail;

    blkx_engine dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_cmp(cmd_cmp),
        .cmd_down(cmd_down), .cmd_rep(cmd_rep), .acc(acc), .flags_in(flags_in),
        .src_in(src_in), .dst_in(dst_in), .cnt_in(cnt_in), .suspend_req(suspend_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .src_out(src_out), .dst_out(dst_out), .cnt_out(cnt_out), .flags_out(flags_out),
        .redo(redo), .tstates(tstates)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_rdata = mem[mem_addr[7:0]];

    // memory responder with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt >= lat_sel) begin
                mem_ack <= 1'b1;
                wcnt    <= 0;
                if (mem_we) begin
                    mem[mem_addr[7:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] ref_flags(input bit cmp, input logic [7:0] fin,
                                             input int v, input int a, input int c);
        int d, h, n, f;
        if (!cmp) begin
            n = (v + a) % 256;
            f = (fin & 8'hC1) | (((n >> 3) & 1) * 8) | (((n >> 1) & 1) * 32);
        end else begin
            d = (a - v + 256) % 256;
            h = (((a ^ v ^ d) >> 4) & 1);
            n = (d - h + 256) % 256;
            f = (fin & 1) | 2 | (d & 128) | ((d == 0) ? 64 : 0) | (h * 16)
                | (((n >> 3) & 1) * 8) | (((n >> 1) & 1) * 32);
        end
        if (c != 0) f = f | 4;
        return f[7:0];
    endfunction

    task automatic run(input bit cmp, input bit dn, input bit rep, input bit susp,
                       input logic [7:0] a, input logic [7:0] fi,
                       input int s0, input int d0, input int c0,
                       input int seed, input int lat);
        logic [7:0] emem [0:255];
        int s, d, c, tst, it, v, dd, mism;
        bit ered, cont;
        logic [7:0] ef;
        string rq;
        for (int i = 0; i < 256; i++) begin
            emem[i] = 8'((i * 37 + seed) % 256);
            mem[i] <= emem[i];
        end
        wr_cnt  <= 0;
        lat_sel = lat;
        // reference model
        s = s0; d = d0; c = c0; tst = 0; it = 0; ered = 0; ef = fi;
        forever begin
            v = emem[s % 256];
            if (!cmp) emem[d % 256] = v[7:0];
            s = dn ? (s + 65535) % 65536 : (s + 1) % 65536;
            if (!cmp) d = dn ? (d + 65535) % 65536 : (d + 1) % 65536;
            c = (c + 65535) % 65536;
            ef = ref_flags(cmp, ef, v, a, c);
            it++;
            dd = (a - v + 256) % 256;
            cont = rep && (c != 0) && !(cmp && dd == 0);
            if (cont) tst += 21; else tst += 16;
            if (cont && susp) begin ered = 1; break; end
            if (!cont) break;
        end
        @(negedge clk);
        cmd_cmp = cmp; cmd_down = dn; cmd_rep = rep; acc = a; flags_in = fi;
        src_in = 16'(s0); dst_in = 16'(d0); cnt_in = 16'(c0);
        suspend_req = susp; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R11", "busy after command", busy, 1);
        while (!done) @(negedge clk);
        rq = cmp ? "R2" : "R1";
        chk(rq, "src pointer", src_out, s);
        chk(rq, "dst pointer", dst_out, cmp ? d0 : d);
        chk(rep ? (cmp ? "R8" : "R7") : "R3", "count", cnt_out, c);
        chk("R3", "P/V flag", flags_out[2], (c != 0) ? 1 : 0);
        chk(cmp ? "R5" : "R4", "main flags", flags_out & 8'hD7, ef & 8'hD7);
        chk(cmp ? "R6" : "R4", "X/Y flags", flags_out & 8'h28, ef & 8'h28);
        chk("R9", "tstates", tstates, tst);
        chk("R10", "redo", redo, ered);
        chk(cmp ? "R2" : "R1", "write count", wr_cnt, cmp ? 0 : it);
        mism = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== emem[i]) mism++;
        chk(cmp ? "R2" : "R1", "memory image mismatches", mism, 0);
        @(negedge clk);
        chk("R11", "done is one cycle", done, 0);
        suspend_req = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        int k;
        int s0, d0, st;
        logic [7:0] a;
        n_chk = 0; n_fail = 0; lat_sel = 0; wr_cnt = 0;
        rst = 1'b1; cmd_valid = 1'b0; cmd_cmp = 1'b0; cmd_down = 1'b0; cmd_rep = 1'b0;
        acc = 8'h00; flags_in = 8'h00; src_in = '0; dst_in = '0; cnt_in = '0;
        suspend_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12", "busy", busy, 0);
        chk("R12", "done", done, 0);
        chk("R12", "mem_req", mem_req, 0);
        chk("R12", "redo", redo, 0);
        chk("R12", "count", cnt_out, 0);
        chk("R12", "flags", flags_out, 0);
        chk("R12", "tstates", tstates, 0);
        chk("R12", "src", src_out, 0);

        // sweep modes, counts, flag inputs and latencies
        k = 0;
        for (int op = 0; op < 2; op++)
            for (int dn = 0; dn < 2; dn++)
                for (int rp = 0; rp < 2; rp++)
                    for (int ci = 0; ci < 3; ci++)
                        for (int fv = 0; fv < 2; fv++) begin
                            s0 = dn ? 16'h0050 : 16'h0040;
                            d0 = dn ? 16'h00C0 : 16'h0080;
                            st = dn ? -2 : 2;
                            // byte two steps ahead: match on the third iteration
                            a = 8'((((s0 + st) % 256) * 37 + k * 11) % 256);
                            run(op[0], dn[0], rp[0], 1'b0, a, fv ? 8'hFF : 8'h00,
                                s0, d0, (ci == 0) ? 1 : ((ci == 1) ? 2 : 5),
                                k * 11, k % 3);
                            k++;
                        end

        // R3: count zero wraps on a single step
        run(1'b0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h41, 16'h0010, 16'h0020, 0, 3, 1);
        // R1: descending pointer wrap below zero
        run(1'b0, 1'b1, 1'b1, 1'b0, 8'h11, 8'h80, 16'h0001, 16'h0000, 3, 7, 0);
        // R8: match on the very first byte
        run(1'b1, 1'b0, 1'b1, 1'b0, 8'((16'h30 * 37 + 9) % 256), 8'h01,
            16'h0030, 16'h0000, 5, 9, 2);
        // R10: suspension of repeated copy and search
        run(1'b0, 1'b0, 1'b1, 1'b1, 8'h22, 8'h00, 16'h0040, 16'h0090, 5, 4, 1);
        run(1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'hC1, 16'h0070, 16'h0000, 6, 5, 0);
        // R10: suspension ignored on single step and on last iteration
        run(1'b0, 1'b0, 1'b0, 1'b1, 8'h33, 8'h00, 16'h0040, 16'h0090, 5, 6, 2);
        run(1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'hFF, 16'h0060, 16'h00A0, 1, 8, 1);
        // R7: longer repeated copy with slow memory
        run(1'b0, 1'b0, 1'b1, 1'b0, 8'h7F, 8'h40, 16'h0000, 16'h0080, 40, 2, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule